// File: doc/BRIEF.md
# Configurable Pin-to-Resource Input Router

This block connects a bank of general-purpose input pins to four internal resources. Two of these resources are timer clock/gate inputs, which are levels. The other two are interrupt request lines, a high-priority line and a low-priority line, which are single-cycle pulses. Every pin has its own 3-bit route code. The code chooses the target. For an interrupt target, the code also chooses whether the request is raised by a rising edge or a falling edge of the pin.

Pins are asynchronous to the core clock, so each pin passes through a two-flop synchroniser first. After that comes edge detection. Any number of pins may choose the same resource. Their contributions are ORed, so a timer input is high while any pin routed to it is high. An interrupt line pulses once in a cycle where at least one routed edge occurs.

The route codes are written through a byte-wide register port. Each configuration byte holds the codes of two neighbouring pins.

Top module: `pinrt_router`

## Requirements
- R1: After synchronous reset, every route code is 000 and all four outputs are low.
- R2: Code 000 and the reserved code 001 both leave the pin unconnected. No output responds to any change of that pin.
- R3: Code 010 drives the pin's synchronised level onto `tmr0_o`, and code 011 drives it onto `tmr1_o`. A pin change shows at the output after the second rising clock edge that follows it.
- R4: Code 100 raises `irq_hi_o` on a rising pin edge, and code 101 raises `irq_lo_o` on a rising pin edge.
- R5: Code 110 raises `irq_hi_o` on a falling pin edge, and code 111 raises `irq_lo_o` on a falling pin edge.
- R6: Each detected edge produces an interrupt pulse exactly one clock wide. The pulse is visible after the second rising clock edge that follows the pin change, and it is gone after the third.
- R7: When several pins select one resource, the output is the OR of their contributions. Simultaneous edges aimed at one interrupt line, whether rising or falling, give a single one-cycle pulse.
- R8: A write to byte address k puts `cfg_wdata[2:0]` into the code of pin 2k and `cfg_wdata[6:4]` into the code of pin 2k+1. Bits 3 and 7 are ignored. A write to an address with no pins changes nothing.
- R9: Changing a pin's code while the pin is steady produces no interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous input pins |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte: two 3-bit route codes |
| tmr0_o | output | 1 | Timer 0 clock/gate level |
| tmr1_o | output | 1 | Timer 1 clock/gate level |
| irq_hi_o | output | 1 | High-priority interrupt request pulse |
| irq_lo_o | output | 1 | Low-priority interrupt request pulse |

## Verification
Suppose a route code is stored in the wrong field or decoded to the wrong target. The bench would then see the wrong output respond within two cycles of the pin change. Suppose instead that the edge history sticks or lags. A pulse would then last two cycles, be missing, or appear after a code change with no pin change, and the bench would see this in the cycle after the expected pulse. The sweep drives every code on every pin through a rise and a fall, and it compares all four outputs in every cycle.

// File: rtl/pinrt_pkg.sv
package pinrt_pkg;

    localparam int CODE_W    = 3;
    localparam int FIELD_GAP = 4;

    typedef enum logic [CODE_W-1:0] {
        RT_NONE    = 3'b000,
        RT_RSVD    = 3'b001,
        RT_TMR0    = 3'b010,
        RT_TMR1    = 3'b011,
        RT_HI_RISE = 3'b100,
        RT_LO_RISE = 3'b101,
        RT_HI_FALL = 3'b110,
        RT_LO_FALL = 3'b111
    } route_code_e;

    typedef struct packed {
        logic tmr0;
        logic tmr1;
        logic irq_hi;
        logic irq_lo;
    } route_vec_t;

    function automatic route_vec_t route_decode(route_code_e code, logic lvl,
                                                logic rise, logic fall);
        route_vec_t v;
        v = '0;
        unique case (code)
            RT_TMR0:    v.tmr0   = lvl;
            RT_TMR1:    v.tmr1   = lvl;
            RT_HI_RISE: v.irq_hi = rise;
            RT_LO_RISE: v.irq_lo = rise;
            RT_HI_FALL: v.irq_hi = fall;
            RT_LO_FALL: v.irq_lo = fall;
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic route_vec_t route_or(route_vec_t a, route_vec_t b);
        return a | b;
    endfunction

endpackage

// File: rtl/pinrt_sync.sv
module pinrt_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pinrt_cfg.sv
module pinrt_cfg
    import pinrt_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [7:0]                 wdata,
    output logic [NUM_PINS*CODE_W-1:0] codes_o
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_field
        localparam int BYTE_IDX = i / 2;
        localparam int BIT_OFS  = (i % 2) * FIELD_GAP;
        logic [CODE_W-1:0] code_q;

        always_ff @(posedge clk) begin
            if (rst)
                code_q <= RT_NONE;
            else if (we && (addr == ADDR_W'(BYTE_IDX)))
                code_q <= wdata[BIT_OFS +: CODE_W];
        end

        assign codes_o[i*CODE_W +: CODE_W] = code_q;
    end

    AST_CODES_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (codes_o == '0)); // R1
endmodule

// File: rtl/pinrt_lane.sv
module pinrt_lane
    import pinrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl_i,
    input  logic [CODE_W-1:0] code_i,
    output route_vec_t        contrib_o
);
    logic hist_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= lvl_i;
    end

    assign rise = lvl_i & ~hist_q;
    assign fall = ~lvl_i & hist_q;

    assign contrib_o = route_decode(route_code_e'(code_i), lvl_i, rise, fall);

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (code_i == RT_RSVD || code_i == RT_NONE) |-> (contrib_o == '0)); // R2
    AST_TMR_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (contrib_o.tmr0 || contrib_o.tmr1) |-> lvl_i); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R6
    AST_NO_EDGE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (lvl_i == hist_q) |-> !(contrib_o.irq_hi || contrib_o.irq_lo)); // R9
endmodule

// File: rtl/pinrt_router.sv
module pinrt_router
    import pinrt_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [7:0]          cfg_wdata,
    output logic                tmr0_o,
    output logic                tmr1_o,
    output logic                irq_hi_o,
    output logic                irq_lo_o
);
    localparam int CODES_W = NUM_PINS * CODE_W;

    logic [NUM_PINS-1:0] lvl;
    logic [CODES_W-1:0]  codes;
    route_vec_t          contrib [NUM_PINS];
    route_vec_t          merged;

    pinrt_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_i),
        .sync_o  (lvl)
    );

    pinrt_cfg #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .codes_o (codes)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
        pinrt_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .lvl_i     (lvl[i]),
            .code_i    (codes[i*CODE_W +: CODE_W]),
            .contrib_o (contrib[i])
        );
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < NUM_PINS; i++)
            merged = route_or(merged, contrib[i]);
    end

    assign tmr0_o   = merged.tmr0;
    assign tmr1_o   = merged.tmr1;
    assign irq_hi_o = merged.irq_hi;
    assign irq_lo_o = merged.irq_lo;

    AST_TMR_NEEDS_PIN: assert property (@(posedge clk) disable iff (rst)
        (tmr0_o || tmr1_o) |-> (|lvl)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(irq_hi_o || irq_lo_o)); // R1
endmodule

// File: tb/pinrt_router_tb.sv
module pinrt_router_tb;
    localparam int NP = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          tmr0, tmr1, ihi, ilo;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [2:0] shadow [NP];

    always #4 clk = ~clk;

    pinrt_router #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .pin_i(pin), .cfg_we(we), .cfg_addr(addr),
        .cfg_wdata(wdata), .tmr0_o(tmr0), .tmr1_o(tmr1),
        .irq_hi_o(ihi), .irq_lo_o(ilo)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [3:0] exp);
        logic [3:0] got;
        got = {tmr0, tmr1, ihi, ilo};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic wr_raw(logic [AW-1:0] a, logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        step();
        we = 1'b0;
    endtask

    task automatic wr_byte(int k);
        wr_raw(AW'(k), {1'b0, shadow[2*k+1], 1'b0, shadow[2*k]});
    endtask

    task automatic clear_all();
        for (int p = 0; p < NP; p++) shadow[p] = 3'b000;
        for (int k = 0; k < NP/2; k++) wr_byte(k);
    endtask

    function automatic string tag(int c);
        if (c < 2) return "R2";
        if (c < 4) return "R3";
        if (c < 6) return "R4";
        return "R5";
    endfunction

    function automatic logic [3:0] exp_lvl(int c, logic l);
        return {(c == 2) & l, (c == 3) & l, 2'b00};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        pin[0] = 1'b1;
        repeat (4) step();
        chk("R1", 4'b0000);
        rst = 1'b0;
        step();
        chk("R1", 4'b0000);
        step();
        chk("R1", 4'b0000);
        pin[0] = 1'b0;
        repeat (3) step();

        // sweep: every code on every pin, rise then fall
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 8; c++) begin
                clear_all();
                shadow[p] = 3'(c);
                wr_byte(p / 2);
                step();
                chk(tag(c), 4'b0000);
                pin[p] = 1'b1;
                step();
                chk(tag(c), 4'b0000);
                step();
                chk(tag(c), exp_lvl(c, 1'b1) | {2'b00, c == 4, c == 5});
                step();
                chk("R6", exp_lvl(c, 1'b1));
                pin[p] = 1'b0;
                step();
                chk(tag(c), exp_lvl(c, 1'b1));
                step();
                chk(tag(c), {2'b00, c == 6, c == 7});
                step();
                chk("R6", 4'b0000);
            end
        end

        // R7: OR of two pins on a timer
        clear_all();
        shadow[0] = 3'b010; shadow[2] = 3'b010;
        shadow[1] = 3'b100; shadow[3] = 3'b110;
        wr_byte(0); wr_byte(1);
        pin[0] = 1'b1; pin[3] = 1'b1;
        repeat (4) step();
        chk("R7", 4'b1000);
        pin[2] = 1'b1; pin[0] = 1'b0;
        repeat (3) step();
        chk("R7", 4'b1000);
        pin[2] = 1'b0;
        repeat (3) step();
        chk("R7", 4'b0000);
        // rise on pin 1 and fall on pin 3 in the same cycle: one pulse
        pin[1] = 1'b1; pin[3] = 1'b0;
        step(); step();
        chk("R7", 4'b0010);
        step();
        chk("R7", 4'b0000);
        pin[1] = 1'b0;
        repeat (3) step();

        // R8: field placement, ignored bits 3 and 7, unmapped address
        clear_all();
        wr_raw(2'd0, 8'b1_010_1_011);
        pin[0] = 1'b1;
        repeat (3) step();
        chk("R8", 4'b0100);
        pin[1] = 1'b1;
        repeat (3) step();
        chk("R8", 4'b1100);
        pin[1:0] = 2'b00;
        repeat (3) step();
        clear_all();
        wr_raw(2'd2, 8'h22);
        wr_raw(2'd3, 8'h33);
        pin = '1;
        step(); step();
        chk("R8", 4'b0000);
        step();
        chk("R8", 4'b0000);

        // R9: code changes while pins are steady high
        for (int c = 4; c < 8; c++) begin
            shadow[0] = 3'(c);
            wr_byte(0);
            chk("R9", 4'b0000);
            step();
            chk("R9", 4'b0000);
        end
        pin = '0;
        step(); step();
        chk("R9", 4'b0001);
        step();
        chk("R6", 4'b0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule